// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Segment Driver

This block turns a serial bit stream into a set of parallel segment drive levels for a passive display. Bits enter on a serial input and step through a chain of stages, one stage per rising edge of a slow shift clock. The shift clock is sampled on the system clock. A direction input chooses which way the chain moves. A serial cascade output presents the stage at the far end of the chosen direction, so several blocks can be chained.

A bank of holding registers copies the chain while a latch-enable input is high. The bank keeps its contents while that input is low, so new data can be shifted in without disturbing the display. A polarity input inverts every segment level. A backplane output follows the same polarity input, which lets the display drive alternate between frames.

The chain and the holding bank both clear on a synchronous active-high reset. After reset, every segment output therefore equals the polarity input.

Top module: `seg_line_driver`

## Requirements
- R1: A synchronous active-high reset clears every chain stage and every holding bit. While the reset is high and after it, each segment output equals the polarity input and the cascade output is 0.
- R2: The chain moves exactly one position on each system clock edge at which the shift clock is sampled high and was sampled low at the previous edge. At every other edge the chain holds, including while the shift clock stays high.
- R3: With the direction input at 1, the serial input enters stage 1 (bit 0), each stage n passes its bit to stage n+1, and the cascade output shows stage NUM_CH (bit NUM_CH-1).
- R4: With the direction input at 0, the serial input enters stage NUM_CH (bit NUM_CH-1), each stage n passes its bit to stage n-1, and the cascade output shows stage 1 (bit 0).
- R5: Neither latch enable nor polarity changes how the chain moves or what the cascade output shows.
- R6: At each system clock edge where latch enable is high, the holding bank loads the chain contents present before that edge. Segment outputs reflect this load after the edge.
- R7: While latch enable is low, the holding bank and the segment outputs keep their values, even while the chain shifts.
- R8: Segment bit i equals holding bit i when polarity is 0, and its inverse when polarity is 1. A change of polarity reaches the segment outputs without waiting for a clock edge.
- R9: The backplane output equals the polarity input at all times, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shiftClk | input | 1 | Shift clock, sampled on clk; a sampled rise moves the chain |
| serIn | input | 1 | Serial data input |
| dirUp | input | 1 | 1: move toward higher stages; 0: move toward lower stages |
| latchEn | input | 1 | High: holding bank reloads from the chain every clk edge |
| polarity | input | 1 | 1 inverts all segment outputs |
| cascadeOut | output | 1 | Last stage in the active direction |
| segOut | output | NUM_CH | Segment drive levels |
| backplane | output | 1 | Backplane level, follows polarity |

## Verification
The bench builds the block with the default NUM_CH of 32. This lets a full 32-bit pattern cross the entire chain, so the cascade output can be compared bit by bit while a second pattern pushes the first one out in each direction. The bench holds the shift clock high for several edges to show that a level alone does not move the chain. It also toggles latch enable and polarity in the middle of shifting, which covers transparent loads, held values and asynchronous inversion.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  // Strobes passed from control to the datapath each system clock.
  typedef struct packed {
    logic shiftStep;  // move the chain one position this edge
    logic shiftUp;    // 1: toward higher stages, 0: toward lower
    logic latchLoad;  // reload the holding bank this edge
  } seg_strobe_t;

endpackage

// File: rtl/seg_drv_ctrl.sv
module seg_drv_ctrl
  import seg_drv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftClk,
  input  logic        dirUp,
  input  logic        latchEn,
  output seg_strobe_t strb
);

  logic shiftClkQ;

  always_ff @(posedge clk) begin
    if (rst) shiftClkQ <= 1'b0;
    else     shiftClkQ <= shiftClk;
  end

  always_comb begin
    strb.shiftStep = shiftClk & ~shiftClkQ & ~rst;
    strb.shiftUp   = dirUp;
    strb.latchLoad = latchEn & ~rst;
  end

  // A held-high shift clock must never yield two steps in a row.
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.shiftStep |=> !strb.shiftStep); // R2

endmodule

// File: rtl/seg_drv_path.sv
module seg_drv_path
  import seg_drv_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  seg_strobe_t       strb,
  input  logic              serIn,
  output logic              cascadeOut,
  output logic [NUM_CH-1:0] latched
);

  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] chain;
  logic [NUM_CH-1:0] chainNext;

  // Per-stage source selection for both directions.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_first
      assign fromBelow = serIn;
    end else begin : g_inner_lo
      assign fromBelow = chain[i-1];
    end
    if (i == LAST) begin : g_last
      assign fromAbove = serIn;
    end else begin : g_inner_hi
      assign fromAbove = chain[i+1];
    end
    assign chainNext[i] = strb.shiftUp ? fromBelow : fromAbove;
  end

  always_ff @(posedge clk) begin
    if (rst)                 chain <= '0;
    else if (strb.shiftStep) chain <= chainNext;
  end

  always_ff @(posedge clk) begin
    if (rst)                 latched <= '0;
    else if (strb.latchLoad) latched <= chain;
  end

  assign cascadeOut = strb.shiftUp ? chain[LAST] : chain[0];

  AST_MOVE_UP: assert property (@(posedge clk) disable iff (rst)
    (strb.shiftStep && strb.shiftUp) |=>
      (chain[0] == $past(serIn)) && (chain[LAST:1] == $past(chain[LAST-1:0]))); // R3

  AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (rst)
    (strb.shiftStep && !strb.shiftUp) |=>
      (chain[LAST] == $past(serIn)) && (chain[LAST-1:0] == $past(chain[LAST:1]))); // R4

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.shiftStep |=> $stable(chain)); // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.latchLoad |=> $stable(latched)); // R7

  AST_BANK_TRACK: assert property (@(posedge clk) disable iff (rst)
    strb.latchLoad |=> (latched == $past(chain))); // R6

endmodule

// File: rtl/seg_drv_polarity.sv
module seg_drv_polarity #(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_CH-1:0] latched,
  input  logic              polarity,
  output logic [NUM_CH-1:0] segOut,
  output logic              backplane
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_seg
    assign segOut[i] = latched[i] ^ polarity;
  end

  assign backplane = polarity;

endmodule

// File: rtl/seg_line_driver.sv
module seg_line_driver
  import seg_drv_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftClk,
  input  logic              serIn,
  input  logic              dirUp,
  input  logic              latchEn,
  input  logic              polarity,
  output logic              cascadeOut,
  output logic [NUM_CH-1:0] segOut,
  output logic              backplane
);

  seg_strobe_t       strb;
  logic [NUM_CH-1:0] latched;

  seg_drv_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shiftClk (shiftClk),
    .dirUp    (dirUp),
    .latchEn  (latchEn),
    .strb     (strb)
  );

  seg_drv_path #(.NUM_CH(NUM_CH)) u_path (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .serIn      (serIn),
    .cascadeOut (cascadeOut),
    .latched    (latched)
  );

  seg_drv_polarity #(.NUM_CH(NUM_CH)) u_pol (
    .latched   (latched),
    .polarity  (polarity),
    .segOut    (segOut),
    .backplane (backplane)
  );

endmodule

// File: tb/sim_seg_line_driver.sv
`timescale 1ns/1ps
module sim_seg_line_driver;

  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftClk = 1'b0, serIn = 1'b0, dirUp = 1'b1, latchEn = 1'b0, polarity = 1'b0;
  logic cascadeOut, backplane;
  logic [N-1:0] segOut;

  always #10 clk = ~clk;  // 50 MHz

  seg_line_driver #(.NUM_CH(N)) u0 (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .serIn(serIn), .dirUp(dirUp),
    .latchEn(latchEn), .polarity(polarity), .cascadeOut(cascadeOut),
    .segOut(segOut), .backplane(backplane)
  );

  typedef struct {
    logic         casc;
    logic [N-1:0] seg;
    logic         bp;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state, written from the requirements.
  logic [N-1:0] mChain = '0;
  logic [N-1:0] mBank = '0;
  logic         mPrevSc = 1'b0;

  // Drive one cycle at the falling edge, update the model at the rising edge, queue expectation.
  task automatic tick(input logic r, input logic sc, input logic si, input logic dir,
                      input logic le, input logic pol, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; shiftClk = sc; serIn = si; dirUp = dir; latchEn = le; polarity = pol;
    @(posedge clk);
    if (r) begin
      mChain = '0; mBank = '0; mPrevSc = 1'b0;
    end else begin
      if (le) mBank = mChain;
      if (sc && !mPrevSc) begin
        if (dir) mChain = {mChain[N-2:0], si};
        else     mChain = {si, mChain[N-1:1]};
      end
      mPrevSc = sc;
    end
    e.casc = dir ? mChain[N-1] : mChain[0];
    e.seg  = mBank ^ {N{pol}};
    e.bp   = pol;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  task automatic shiftBit(input logic si, input logic dir, input logic le,
                          input logic pol, input string tag);
    tick(1'b0, 1'b1, si, dir, le, pol, tag);
    tick(1'b0, 1'b0, si, dir, le, pol, tag);
  endtask

  // Monitor: compare queued expectations a quarter cycle after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (cascadeOut !== e.casc || segOut !== e.seg || backplane !== e.bp) begin
          errors++;
          $display("FAIL %s: casc=%0b exp %0b seg=%h exp %h bp=%0b exp %0b",
                   e.tag, cascadeOut, e.casc, segOut, e.seg, backplane, e.bp);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #(2_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] patA;
    logic [N-1:0] patB;
    patA = 32'hA5C3_1E7F;
    patB = 32'h3C96_F00D;

    // R1: reset with polarity high, then low
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");

    // R3: shift patA upward, latch closed (R7 holds segments at zero)
    for (int i = N-1; i >= 0; i--) shiftBit(patA[i], 1'b1, 1'b0, 1'b0, "R3");
    // R6: open the latch, then close it
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // R8 and R9: flip polarity on the held bank
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    // R3 cascade: push patB upward, patA leaves bit by bit; R7 segments held
    for (int i = N-1; i >= 0; i--) shiftBit(patB[i], 1'b1, 1'b0, 1'b0, "R7");

    // R2: shift clock held high does not keep moving
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");

    // R4: shift patA downward, cascade from stage 1
    for (int i = 0; i < N; i++) shiftBit(patA[i], 1'b0, 1'b0, 1'b1, "R4");
    for (int i = 0; i < N; i++) shiftBit(patB[i], 1'b0, 1'b0, 1'b0, "R4");

    // R5 and R6: shift with the latch transparent and polarity toggling
    for (int i = 0; i < 20; i++) shiftBit(patA[i], 1'b1, 1'b1, 1'(i % 2), "R5");
    for (int i = 0; i < 12; i++) shiftBit(patB[i], 1'b0, 1'b1, 1'(i % 3 == 0), "R6");
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

    // R1: mid-run reset
    tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R1");

    @(posedge clk);
    #8;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule